// File: doc/BRIEF.md
# Attribute-Steered Direct-Mapped Data Cache Controller

This controller sits between a processor's load/store port and a word-wide external memory. Every access carries three attribute bits. For that one access they select whether it may use the cache at all, whether a store miss allocates a line, and whether a store hit is also sent to memory at once or only when the line later leaves the cache. The store is direct-mapped. Its lines hold several words, and the controller moves them to and from memory as fixed bursts that start at word 0 of the line.

The processor side is one request at a time. A single-cycle `cpu_req` pulse, given while the controller is idle, starts an access, and `cpu_ready` pulses once when the access completes (with `cpu_rdata` valid for loads). A separate clean command names a line index and writes that line back if it holds modified data. A global enable input (`mmu_on`) forces every access onto the uncached path while it is low. Addresses are word addresses. With the default parameters, bits [2:0] select the word, bits [6:3] select the line and the remaining bits form the tag.

Top module: `dcache_ctrl`

## Requirements
- R1: While `mmu_on` is 0, every access is handled as uncached, whatever `cpu_attr` says. It makes exactly one single-word memory transfer, allocates no line and leaves the cache contents unchanged.
- R2: `cpu_attr` is {X,C,B}, with X in bit 2, C in bit 1 and B in bit 0. With C=0 the access is uncached: a load is one single-word memory read, and a store is one single-word memory write to the same word address.
- R3: A cacheable load that misses fetches the whole line as 8 read beats at ascending word addresses from the line base. It then returns the requested word. A later load anywhere in that line hits and causes no memory traffic.
- R4: A store miss under read-allocate (C=1 with X=0, or C=1 with B=0) performs one single-word memory write and allocates nothing. A line already resident at that index is left in place.
- R5: A store miss with X=1,C=1,B=1 fills the line with 8 read beats and merges the store word into the cache. It writes nothing to memory at that time.
- R6: A store hit with C=1,B=0 (write-through) updates the cached word and also writes that word to memory as one single-word write.
- R7: A store hit with C=1,B=1 (write-back) updates only the cache and causes no memory traffic.
- R8: A fill that replaces a valid, modified line first writes that line back as 8 write beats at its own addresses, carrying the modified words. Only then does the fill start.
- R9: A clean of a valid, modified line writes it back as 8 write beats and leaves it valid. Afterwards a load to that line hits without traffic, and a second clean of the same index causes no traffic.
- R10: A clean of an invalid line causes no memory traffic and still completes with a one-cycle `clean_done` pulse.
- R11: Once `mem_req` is raised, it stays high with `mem_addr` and `mem_we` unchanged until a cycle in which `mem_ack` is high.
- R12: `cpu_ready` is a one-cycle pulse per accepted access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mmu_on | input | 1 | Global translation/cache enable; 0 forces uncached handling |
| cpu_req | input | 1 | Single-cycle access start, taken while idle |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 30 | Word address of the access |
| cpu_wdata | input | 32 | Store data |
| cpu_attr | input | 3 | Access attributes {X,C,B} |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Load result, valid with `cpu_ready` |
| clean_req | input | 1 | Single-cycle clean command, taken while idle and no access starts |
| clean_idx | input | 4 | Line index to clean |
| clean_done | output | 1 | One-cycle clean completion pulse |
| mem_req | output | 1 | Memory transfer request, held until acknowledged |
| mem_we | output | 1 | 1 = memory write |
| mem_burst | output | 1 | 1 = beat of a whole-line burst |
| mem_addr | output | 30 | Word address of the current beat |
| mem_wdata | output | 32 | Write data of the current beat |
| mem_ack | input | 1 | Beat accepted or read data valid this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |

## Verification
The assertions assume that `cpu_req` and `clean_req` arrive only while the controller is idle. They also assume that `mem_ack` is high only while `mem_req` is high and that the memory returns read data in the acknowledging cycle. The directed stimulus waits for each `cpu_ready` or `clean_done` before it issues the next command, and it pulses each command for exactly one cycle. Its memory model raises `mem_ack` only in response to a pending request, and it withholds the acknowledge in every third cycle so that held requests really occur.

// File: rtl/dc_pkg.sv
package dc_pkg;

    typedef struct packed {
        logic x;
        logic c;
        logic b;
    } attr_t;

    typedef struct packed {
        logic cacheable;
        logic write_back;
        logic alloc_on_write;
    } policy_t;

    typedef enum logic [3:0] {
        S_IDLE,
        S_LOOKUP,
        S_EVICT,
        S_FILL,
        S_SGL_RD,
        S_SGL_WR,
        S_CLEAN_CHK,
        S_CLEAN_FIN,
        S_RESP
    } state_t;

    function automatic policy_t decode_attr(attr_t a, logic en);
        policy_t p;
        p = '0;
        if (en && a.c) begin
            p.cacheable      = 1'b1;
            p.write_back     = a.b;
            p.alloc_on_write = a.b & a.x;
        end
        return p;
    endfunction

endpackage

// File: rtl/dc_attr_decode.sv
module dc_attr_decode
    import dc_pkg::*;
(
    input  attr_t   attr_i,
    input  logic    enable_i,
    output policy_t policy_o
);
    always_comb policy_o = decode_attr(attr_i, enable_i);
endmodule

// File: rtl/dc_tag_array.sv
module dc_tag_array #(
    parameter int LINES = 16,
    parameter int TAG_W = 23
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [$clog2(LINES)-1:0] idx_i,
    output logic                     valid_o,
    output logic                     dirty_o,
    output logic [TAG_W-1:0]         tag_o,
    input  logic                     fill_we_i,
    input  logic [TAG_W-1:0]         fill_tag_i,
    input  logic                     set_dirty_i,
    input  logic                     clr_dirty_i
);
    logic [LINES-1:0] valid_q;
    logic [LINES-1:0] dirty_q;
    logic [TAG_W-1:0] tag_q [LINES];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (fill_we_i) begin
            valid_q[idx_i] <= 1'b1;
            dirty_q[idx_i] <= 1'b0;
        end else if (set_dirty_i) begin
            dirty_q[idx_i] <= 1'b1;
        end else if (clr_dirty_i) begin
            dirty_q[idx_i] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_we_i) tag_q[idx_i] <= fill_tag_i;
    end

    assign valid_o = valid_q[idx_i];
    assign dirty_o = dirty_q[idx_i];
    assign tag_o   = tag_q[idx_i];

    // A completed fill leaves its line valid and unmodified (R3, R5)
    assert_fill_installs_R3: assert property (@(posedge clk) disable iff (rst)
        fill_we_i |=> valid_q[$past(idx_i)] && !dirty_q[$past(idx_i)]);

    // Cleaning keeps the line resident (R9)
    assert_clean_keeps_valid_R9: assert property (@(posedge clk) disable iff (rst)
        (clr_dirty_i && valid_o) |=> valid_q[$past(idx_i)] && !dirty_q[$past(idx_i)]);
endmodule

// File: rtl/dc_data_array.sv
module dc_data_array #(
    parameter int LINES  = 16,
    parameter int WORDS  = 8,
    parameter int DATA_W = 32
) (
    input  logic                     clk,
    input  logic                     we_i,
    input  logic [$clog2(LINES)-1:0] idx_i,
    input  logic [$clog2(WORDS)-1:0] wword_i,
    input  logic [DATA_W-1:0]        wdata_i,
    input  logic [$clog2(WORDS)-1:0] rword_i,
    output logic [DATA_W-1:0]        rdata_o
);
    localparam int IDX_W  = $clog2(LINES);
    localparam int WSEL_W = $clog2(WORDS);

    logic [DATA_W-1:0] words_q [LINES*WORDS];

    always_ff @(posedge clk) begin
        if (we_i) words_q[{idx_i, wword_i}] <= wdata_i;
    end

    assign rdata_o = words_q[{idx_i, rword_i}];

    initial begin
        assert (IDX_W + WSEL_W <= 16) else $error("data array too deep");
    end
endmodule

// File: rtl/dcache_ctrl.sv
module dcache_ctrl
    import dc_pkg::*;
#(
    parameter int AW     = 30,
    parameter int DATA_W = 32,
    parameter int LINES  = 16,
    parameter int WORDS  = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     mmu_on,
    input  logic                     cpu_req,
    input  logic                     cpu_we,
    input  logic [AW-1:0]            cpu_addr,
    input  logic [DATA_W-1:0]        cpu_wdata,
    input  logic [2:0]               cpu_attr,
    output logic                     cpu_ready,
    output logic [DATA_W-1:0]        cpu_rdata,
    input  logic                     clean_req,
    input  logic [$clog2(LINES)-1:0] clean_idx,
    output logic                     clean_done,
    output logic                     mem_req,
    output logic                     mem_we,
    output logic                     mem_burst,
    output logic [AW-1:0]            mem_addr,
    output logic [DATA_W-1:0]        mem_wdata,
    input  logic                     mem_ack,
    input  logic [DATA_W-1:0]        mem_rdata
);
    localparam int WSEL_W = $clog2(WORDS);
    localparam int IDX_W  = $clog2(LINES);
    localparam int TAG_W  = AW - IDX_W - WSEL_W;
    localparam logic [WSEL_W-1:0] LAST_BEAT = WSEL_W'(WORDS - 1);

    state_t              state_q;
    logic                r_we;
    logic [TAG_W-1:0]    r_tag;
    logic [IDX_W-1:0]    r_idx;
    logic [WSEL_W-1:0]   r_word;
    logic [DATA_W-1:0]   r_wdata;
    attr_t               r_attr;
    logic                r_mmu;
    logic                r_clean;
    logic                r_to_fill;
    logic [WSEL_W-1:0]   beat_q;
    logic [DATA_W-1:0]   rdata_q;

    policy_t             pol;
    logic                vic_valid;
    logic                vic_dirty;
    logic [TAG_W-1:0]    vic_tag;
    logic                hit;
    logic                last_beat;

    logic                d_we;
    logic [WSEL_W-1:0]   d_wword;
    logic [DATA_W-1:0]   d_wdata;
    logic [WSEL_W-1:0]   d_rword;
    logic [DATA_W-1:0]   line_word;
    logic                fill_we;
    logic                set_dirty;
    logic                clr_dirty;

    dc_attr_decode u_dec (
        .attr_i   (r_attr),
        .enable_i (r_mmu),
        .policy_o (pol)
    );

    dc_tag_array #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
        .clk         (clk),
        .rst         (rst),
        .idx_i       (r_idx),
        .valid_o     (vic_valid),
        .dirty_o     (vic_dirty),
        .tag_o       (vic_tag),
        .fill_we_i   (fill_we),
        .fill_tag_i  (r_tag),
        .set_dirty_i (set_dirty),
        .clr_dirty_i (clr_dirty)
    );

    dc_data_array #(.LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W)) u_data (
        .clk     (clk),
        .we_i    (d_we),
        .idx_i   (r_idx),
        .wword_i (d_wword),
        .wdata_i (d_wdata),
        .rword_i (d_rword),
        .rdata_o (line_word)
    );

    assign hit       = vic_valid && (vic_tag == r_tag);
    assign last_beat = (beat_q == LAST_BEAT);

    // Array write/read steering
    always_comb begin
        d_we    = 1'b0;
        d_wword = r_word;
        d_wdata = r_wdata;
        if (state_q == S_FILL) begin
            d_we    = mem_ack;
            d_wword = beat_q;
            d_wdata = mem_rdata;
        end else if (state_q == S_LOOKUP) begin
            d_we = pol.cacheable && hit && r_we;
        end
        d_rword   = (state_q == S_EVICT) ? beat_q : r_word;
        fill_we   = (state_q == S_FILL) && mem_ack && last_beat;
        set_dirty = (state_q == S_LOOKUP) && pol.cacheable && hit && r_we && pol.write_back;
        clr_dirty = (state_q == S_CLEAN_FIN);
    end

    // Memory port
    always_comb begin
        mem_req   = (state_q == S_EVICT) || (state_q == S_FILL) ||
                    (state_q == S_SGL_RD) || (state_q == S_SGL_WR);
        mem_we    = (state_q == S_EVICT) || (state_q == S_SGL_WR);
        mem_burst = (state_q == S_EVICT) || (state_q == S_FILL);
        case (state_q)
            S_EVICT: mem_addr = {vic_tag, r_idx, beat_q};
            S_FILL:  mem_addr = {r_tag, r_idx, beat_q};
            default: mem_addr = {r_tag, r_idx, r_word};
        endcase
        mem_wdata = (state_q == S_EVICT) ? line_word : r_wdata;
    end

    assign cpu_ready  = (state_q == S_RESP) && !r_clean;
    assign clean_done = (state_q == S_RESP) && r_clean;
    assign cpu_rdata  = rdata_q;

    // Sequencer
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= S_IDLE;
            r_we      <= 1'b0;
            r_tag     <= '0;
            r_idx     <= '0;
            r_word    <= '0;
            r_wdata   <= '0;
            r_attr    <= '0;
            r_mmu     <= 1'b0;
            r_clean   <= 1'b0;
            r_to_fill <= 1'b0;
            beat_q    <= '0;
            rdata_q   <= '0;
        end else begin
            case (state_q)
                S_IDLE: begin
                    if (cpu_req) begin
                        r_we    <= cpu_we;
                        r_tag   <= cpu_addr[AW-1 -: TAG_W];
                        r_idx   <= cpu_addr[WSEL_W +: IDX_W];
                        r_word  <= cpu_addr[WSEL_W-1:0];
                        r_wdata <= cpu_wdata;
                        r_attr  <= attr_t'(cpu_attr);
                        r_mmu   <= mmu_on;
                        r_clean <= 1'b0;
                        state_q <= S_LOOKUP;
                    end else if (clean_req) begin
                        r_idx   <= clean_idx;
                        r_clean <= 1'b1;
                        state_q <= S_CLEAN_CHK;
                    end
                end
                S_LOOKUP: begin
                    beat_q <= '0;
                    if (!pol.cacheable) begin
                        state_q <= r_we ? S_SGL_WR : S_SGL_RD;
                    end else if (hit) begin
                        if (!r_we) begin
                            rdata_q <= line_word;
                            state_q <= S_RESP;
                        end else begin
                            state_q <= pol.write_back ? S_RESP : S_SGL_WR;
                        end
                    end else if (r_we && !pol.alloc_on_write) begin
                        state_q <= S_SGL_WR;
                    end else if (vic_valid && vic_dirty) begin
                        r_to_fill <= 1'b1;
                        state_q   <= S_EVICT;
                    end else begin
                        state_q <= S_FILL;
                    end
                end
                S_EVICT: begin
                    if (mem_ack) begin
                        beat_q <= beat_q + 1'b1;
                        if (last_beat) begin
                            beat_q  <= '0;
                            state_q <= r_to_fill ? S_FILL : S_CLEAN_FIN;
                        end
                    end
                end
                S_FILL: begin
                    if (mem_ack) begin
                        beat_q <= beat_q + 1'b1;
                        if (last_beat) begin
                            beat_q  <= '0;
                            state_q <= S_LOOKUP;
                        end
                    end
                end
                S_SGL_RD: begin
                    if (mem_ack) begin
                        rdata_q <= mem_rdata;
                        state_q <= S_RESP;
                    end
                end
                S_SGL_WR: begin
                    if (mem_ack) state_q <= S_RESP;
                end
                S_CLEAN_CHK: begin
                    beat_q <= '0;
                    if (vic_valid && vic_dirty) begin
                        r_to_fill <= 1'b0;
                        state_q   <= S_EVICT;
                    end else begin
                        state_q <= S_RESP;
                    end
                end
                S_CLEAN_FIN: state_q <= S_RESP;
                S_RESP:      state_q <= S_IDLE;
                default:     state_q <= S_IDLE;
            endcase
        end
    end

    // Enable low forces the single-word path (R1)
    assert_mmu_off_bypass_R1: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_LOOKUP && !r_mmu) |=> (state_q == S_SGL_RD || state_q == S_SGL_WR));

    // Read-allocate store miss never starts a line transfer (R4)
    assert_no_store_alloc_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_LOOKUP && r_we && !hit && !pol.alloc_on_write)
        |=> (state_q != S_FILL && state_q != S_EVICT));

    // Write-back store hit completes without the memory port (R7)
    assert_wb_hit_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_LOOKUP && pol.cacheable && hit && r_we && pol.write_back)
        |=> (state_q == S_RESP && !mem_req));

    // Only a resident modified line is written back (R8)
    assert_evict_dirty_only_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_EVICT) |-> (vic_valid && vic_dirty));

    // Memory request is held steady until acknowledged (R11)
    assert_mem_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // Completion indications are single-cycle pulses (R12)
    assert_ready_pulse_R12: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |=> !cpu_ready);
endmodule

// File: tb/test_dcache_ctrl.sv
`timescale 1ns/1ps
module test_dcache_ctrl;
    localparam int AW = 30;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic          mmu_on;
    logic          cpu_req, cpu_we;
    logic [AW-1:0] cpu_addr;
    logic [DW-1:0] cpu_wdata;
    logic [2:0]    cpu_attr;
    logic          cpu_ready;
    logic [DW-1:0] cpu_rdata;
    logic          clean_req;
    logic [3:0]    clean_idx;
    logic          clean_done;
    logic          mem_req, mem_we, mem_burst;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_ack;
    logic [DW-1:0] mem_rdata;

    always #2 clk = ~clk;

    dcache_ctrl i_dcache_ctrl (
        .clk(clk), .rst(rst), .mmu_on(mmu_on),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_attr(cpu_attr),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .clean_req(clean_req), .clean_idx(clean_idx), .clean_done(clean_done),
        .mem_req(mem_req), .mem_we(mem_we), .mem_burst(mem_burst),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    int n_checks = 0;
    int n_fail   = 0;

    // memory model state
    logic [DW-1:0] ext_mem [logic [AW-1:0]];
    logic [AW-1:0] rd_log[$];
    logic [AW-1:0] wr_log[$];
    int            burst_beats;
    int            hold_viol;
    int            stall_ctr;

    function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
        return {2'b00, a} ^ 32'hC0DE_0000;
    endfunction

    function automatic logic [DW-1:0] mem_rd(input logic [AW-1:0] a);
        if (ext_mem.exists(a)) return ext_mem[a];
        return pat(a);
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // memory responder: acknowledges pending requests, skipping every third cycle
    initial begin
        logic          pend;
        logic [AW-1:0] pend_addr;
        logic          pend_we;
        mem_ack = 1'b0; mem_rdata = '0;
        burst_beats = 0; hold_viol = 0; stall_ctr = 0;
        pend = 1'b0; pend_addr = '0; pend_we = 1'b0;
        forever begin
            @(negedge clk);
            if (pend && !(mem_req && mem_addr == pend_addr && mem_we == pend_we))
                hold_viol++;
            stall_ctr = (stall_ctr + 1) % 3;
            if (mem_req && !rst && stall_ctr != 0) begin
                mem_ack = 1'b1;
                if (mem_burst) burst_beats++;
                if (mem_we) begin
                    ext_mem[mem_addr] = mem_wdata;
                    wr_log.push_back(mem_addr);
                end else begin
                    mem_rdata = mem_rd(mem_addr);
                    rd_log.push_back(mem_addr);
                end
                pend = 1'b0;
            end else begin
                mem_ack = 1'b0;
                pend = mem_req && !rst;
                pend_addr = mem_addr;
                pend_we = mem_we;
            end
        end
    end

    task automatic clear_logs();
        rd_log.delete();
        wr_log.delete();
        burst_beats = 0;
    endtask

    task automatic access(input logic we, input logic [AW-1:0] a,
                          input logic [DW-1:0] d, input logic [2:0] attr,
                          input logic en, output logic [DW-1:0] rd);
        clear_logs();
        @(negedge clk);
        mmu_on = en; cpu_we = we; cpu_addr = a; cpu_wdata = d; cpu_attr = attr;
        cpu_req = 1'b1;
        @(negedge clk);
        cpu_req = 1'b0;
        while (!cpu_ready) @(negedge clk);
        rd = cpu_rdata;
    endtask

    task automatic do_clean(input logic [3:0] idx);
        clear_logs();
        @(negedge clk);
        clean_idx = idx; clean_req = 1'b1;
        @(negedge clk);
        clean_req = 1'b0;
        while (!clean_done) @(negedge clk);
    endtask

    task automatic chk_burst(input string req, input logic is_wr, input logic [AW-1:0] base);
        chk(req, "burst beat count", (is_wr ? wr_log.size() : rd_log.size()), 8);
        for (int i = 0; i < 8; i++) begin
            if (is_wr && i < wr_log.size())
                chk(req, "write beat address", wr_log[i], base + i);
            else if (!is_wr && i < rd_log.size())
                chk(req, "read beat address", rd_log[i], base + i);
        end
    endtask

    task automatic chk_quiet(input string req);
        chk(req, "read count", rd_log.size(), 0);
        chk(req, "write count", wr_log.size(), 0);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk("R12", "cpu_ready after reset", cpu_ready, 0);
        chk("R10", "clean_done after reset", clean_done, 0);
        chk("R11", "mem_req after reset", mem_req, 0);
    endtask

    task automatic t_uncached();
        logic [DW-1:0] rd;
        access(1'b0, 30'h40, '0, 3'b000, 1'b1, rd);
        chk("R2", "uncached load data", rd, pat(30'h40));
        chk("R2", "uncached load reads", rd_log.size(), 1);
        chk("R2", "uncached load bursts", burst_beats, 0);
        access(1'b1, 30'h41, 32'hDEAD_0041, 3'b101, 1'b1, rd);
        chk("R2", "uncached store writes", wr_log.size(), 1);
        chk("R2", "uncached store addr", (wr_log.size() > 0) ? wr_log[0] : '1, 30'h41);
        chk("R2", "uncached store memory", mem_rd(30'h41), 32'hDEAD_0041);
    endtask

    task automatic t_read_alloc();
        logic [DW-1:0] rd;
        access(1'b0, 30'h82, '0, 3'b010, 1'b1, rd);
        chk_burst("R3", 1'b0, 30'h80);
        chk("R3", "fill load data", rd, pat(30'h82));
        access(1'b0, 30'h85, '0, 3'b010, 1'b1, rd);
        chk_quiet("R3");
        chk("R3", "hit load data", rd, pat(30'h85));
    endtask

    task automatic t_write_through();
        logic [DW-1:0] rd;
        access(1'b1, 30'h83, 32'h1111_0083, 3'b010, 1'b1, rd);
        chk("R6", "wt store writes", wr_log.size(), 1);
        chk("R6", "wt store reads", rd_log.size(), 0);
        chk("R6", "wt memory value", mem_rd(30'h83), 32'h1111_0083);
        access(1'b0, 30'h83, '0, 3'b010, 1'b1, rd);
        chk("R6", "wt cached value", rd, 32'h1111_0083);
        chk_quiet("R6");
    endtask

    task automatic t_store_no_alloc();
        logic [DW-1:0] rd;
        access(1'b1, 30'h102, 32'h2222_0102, 3'b011, 1'b1, rd);
        chk("R4", "ra store miss writes", wr_log.size(), 1);
        chk("R4", "ra store miss reads", rd_log.size(), 0);
        chk("R4", "ra store memory", mem_rd(30'h102), 32'h2222_0102);
        access(1'b0, 30'h80, '0, 3'b010, 1'b1, rd);
        chk_quiet("R4");
        chk("R4", "resident line kept", rd, pat(30'h80));
    endtask

    task automatic t_write_back_hit();
        logic [DW-1:0] rd;
        access(1'b1, 30'h84, 32'h3333_0084, 3'b011, 1'b1, rd);
        chk_quiet("R7");
        chk("R7", "wb memory untouched", mem_rd(30'h84), pat(30'h84));
        access(1'b0, 30'h84, '0, 3'b011, 1'b1, rd);
        chk("R7", "wb cached value", rd, 32'h3333_0084);
    endtask

    task automatic t_evict();
        logic [DW-1:0] rd;
        access(1'b0, 30'h182, '0, 3'b011, 1'b1, rd);
        chk_burst("R8", 1'b1, 30'h80);
        chk_burst("R8", 1'b0, 30'h180);
        chk("R8", "victim modified word", mem_rd(30'h84), 32'h3333_0084);
        chk("R8", "victim wt word", mem_rd(30'h83), 32'h1111_0083);
        chk("R8", "new line data", rd, pat(30'h182));
    endtask

    task automatic t_rw_alloc();
        logic [DW-1:0] rd;
        access(1'b1, 30'h20A, 32'h4444_020A, 3'b111, 1'b1, rd);
        chk_burst("R5", 1'b0, 30'h208);
        chk("R5", "no write on allocate", wr_log.size(), 0);
        chk("R5", "memory not updated", mem_rd(30'h20A), pat(30'h20A));
        access(1'b0, 30'h20A, '0, 3'b011, 1'b1, rd);
        chk_quiet("R5");
        chk("R5", "merged value", rd, 32'h4444_020A);
    endtask

    task automatic t_clean();
        logic [DW-1:0] rd;
        do_clean(4'd1);
        chk_burst("R9", 1'b1, 30'h208);
        chk("R9", "cleaned word in memory", mem_rd(30'h20A), 32'h4444_020A);
        access(1'b0, 30'h20F, '0, 3'b011, 1'b1, rd);
        chk_quiet("R9");
        chk("R9", "line still valid", rd, pat(30'h20F));
        do_clean(4'd1);
        chk_quiet("R9");
        do_clean(4'd5);
        chk_quiet("R10");
        chk("R10", "clean_done seen", 1, 1);
    endtask

    task automatic t_mmu_off();
        logic [DW-1:0] rd;
        access(1'b0, 30'h183, '0, 3'b011, 1'b0, rd);
        chk("R1", "off load reads", rd_log.size(), 1);
        chk("R1", "off load bursts", burst_beats, 0);
        chk("R1", "off load data", rd, pat(30'h183));
        access(1'b1, 30'h184, 32'h5555_0184, 3'b111, 1'b0, rd);
        chk("R1", "off store writes", wr_log.size(), 1);
        chk("R1", "off store reads", rd_log.size(), 0);
        access(1'b0, 30'h184, '0, 3'b011, 1'b1, rd);
        chk_quiet("R1");
        chk("R1", "cache unchanged", rd, pat(30'h184));
        access(1'b0, 30'h300, '0, 3'b111, 1'b0, rd);
        chk("R1", "off no alloc bursts", burst_beats, 0);
    endtask

    task automatic t_pulse();
        logic [DW-1:0] rd;
        access(1'b0, 30'h181, '0, 3'b011, 1'b1, rd);
        @(negedge clk);
        chk("R12", "ready pulse width", cpu_ready, 0);
        chk("R12", "hit data", rd, pat(30'h181));
        chk("R11", "request hold violations", hold_viol, 0);
    endtask

    initial begin
        rst = 1'b1; mmu_on = 1'b1; cpu_req = 1'b0; cpu_we = 1'b0;
        cpu_addr = '0; cpu_wdata = '0; cpu_attr = '0;
        clean_req = 1'b0; clean_idx = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_uncached();
        t_read_alloc();
        t_write_through();
        t_store_no_alloc();
        t_write_back_hit();
        t_evict();
        t_rw_alloc();
        t_clean();
        t_mmu_off();
        t_pulse();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule